// File: doc/BRIEF.md
# Paged Address Translator

This block maps a 16-bit CPU address onto a 20-bit physical address in 4 KB pages. The four top address bits pick one of 16 logical pages. A small translation store returns an 8-bit physical page number for that page, and the block joins that number to the unchanged 12-bit offset. Every logical page has two entries: one for reads and one for writes. A page can therefore be read from one physical frame and written to another. Opcode fetches are reads and use the read entries.

The store holds four complete translation sets. Software programs entries through two I/O ports. An index port chooses a set, a direction and a page. A data port writes the chosen entry, and each data write advances the index by one. A third port makes one set active. That choice takes effect on the first cycle after the I/O write, so the next fetch already goes through the new mapping. Translation is combinational from the CPU address and strobes. All pins are plain control and data pins. No stream interface exists, so no back-pressure applies: every I/O write is accepted on the clock edge where `io_wr` is high.

Top module: `pxlat_unit`

## Requirements
- R1: phys_addr[11:0] always equals cpu_addr[11:0].
- R2: phys_addr[19:12] is the entry of the active set for logical page cpu_addr[15:12]. The write entry is used when cpu_wr is 1. The read entry is used otherwise, including for opcode fetches signalled by cpu_rd.
- R3: Read and write entries of the same page are independent. Writing one leaves the other unchanged.
- R4: An I/O write with io_addr=0 loads the index from io_data[6:0]. The fields are set in bits 6:5, direction in bit 4 (1 = write map) and page in bits 3:0.
- R5: An I/O write with io_addr=1 stores io_data into the entry named by the index, then increments the index. The 7-bit index wraps from 127 to 0.
- R6: An I/O write with io_addr=2 makes set io_data[1:0] active. Translation uses it from the next cycle.
- R7: Programming an inactive set leaves translation unchanged until that set is selected.
- R8: After reset, set 0 is active and the index is 0. Every entry of every set, in both directions, holds the physical page equal to its logical page number (identity map).
- R9: phys_valid is 1 exactly when cpu_rd or cpu_wr is 1.
- R10: I/O writes with io_addr=3 change neither the active set, the index, nor any entry.
- R11: When cpu_rd and cpu_wr are both 1, the write entry is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Logical CPU address |
| cpu_rd | input | 1 | Read or opcode-fetch strobe |
| cpu_wr | input | 1 | Write strobe |
| io_wr | input | 1 | I/O write strobe for the control ports |
| io_addr | input | 2 | Control port: 0 index, 1 data, 2 set select, 3 unused |
| io_data | input | 8 | I/O write data |
| phys_addr | output | 20 | Translated physical address |
| phys_valid | output | 1 | A CPU access is in progress |

## Verification
The assertions check on every cycle that:
- the offset passes through unchanged;
- index loads, index increments and set selections land one cycle after their I/O write;
- the physical address holds still while the CPU address, the strobe and the control ports hold still.

Other behaviours only show up across sequences, so the bench scenarios cover them:
- which stored entry a given access reaches;
- that read and write maps stay apart;
- the index wrap carrying into set 0;
- that inactive sets stay isolated.

// File: rtl/pxlat_pkg.sv
package pxlat_pkg;
  typedef enum logic [1:0] {
    PORT_INDEX  = 2'd0,
    PORT_DATA   = 2'd1,
    PORT_SELECT = 2'd2,
    PORT_SPARE  = 2'd3
  } io_port_e;

  localparam int DIR_READ  = 0;
  localparam int DIR_WRITE = 1;
endpackage

// File: rtl/pxlat_ctrl.sv
module pxlat_ctrl
  import pxlat_pkg::*;
#(
  parameter int SETS      = 4,
  parameter int PAGE_BITS = 4,
  parameter int PPN_W     = 8,
  localparam int SET_W    = $clog2(SETS),
  localparam int IDX_W    = SET_W + 1 + PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 io_wr,
  input  logic [1:0]           io_addr,
  input  logic [PPN_W-1:0]     io_data,
  output logic                 ent_we,
  output logic [SET_W-1:0]     ent_set,
  output logic                 ent_dir,
  output logic [PAGE_BITS-1:0] ent_page,
  output logic [PPN_W-1:0]     ent_data,
  output logic [SET_W-1:0]     act_set,
  output logic [IDX_W-1:0]     idx_q
);
  io_port_e port;
  logic     hit_index, hit_data, hit_select;

  always_comb begin
    port       = io_port_e'(io_addr);
    hit_index  = io_wr && (port == PORT_INDEX);
    hit_data   = io_wr && (port == PORT_DATA);
    hit_select = io_wr && (port == PORT_SELECT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q   <= '0;
      act_set <= '0;
    end else begin
      if (hit_index)      idx_q <= io_data[IDX_W-1:0];
      else if (hit_data)  idx_q <= idx_q + 1'b1;
      if (hit_select)     act_set <= io_data[SET_W-1:0];
    end
  end

  assign ent_we   = hit_data;
  assign ent_set  = idx_q[IDX_W-1 -: SET_W];
  assign ent_dir  = idx_q[PAGE_BITS];
  assign ent_page = idx_q[PAGE_BITS-1:0];
  assign ent_data = io_data;
endmodule

// File: rtl/pxlat_tables.sv
module pxlat_tables #(
  parameter int SETS      = 4,
  parameter int PAGE_BITS = 4,
  parameter int PPN_W     = 8,
  localparam int SET_W    = $clog2(SETS),
  localparam int PAGES    = 1 << PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ent_we,
  input  logic [SET_W-1:0]     ent_set,
  input  logic                 ent_dir,
  input  logic [PAGE_BITS-1:0] ent_page,
  input  logic [PPN_W-1:0]     ent_data,
  input  logic [SET_W-1:0]     look_set,
  input  logic                 look_dir,
  input  logic [PAGE_BITS-1:0] look_page,
  output logic [PPN_W-1:0]     look_ppn
);
  logic [PPN_W-1:0] ent [SETS][2][PAGES];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar d = 0; d < 2; d++) begin : g_dir
      for (genvar p = 0; p < PAGES; p++) begin : g_page
        logic sel;
        assign sel = ent_we && (ent_set == SET_W'(s)) &&
                     (ent_dir == 1'(d)) && (ent_page == PAGE_BITS'(p));
        always_ff @(posedge clk) begin
          if (!rst_n)   ent[s][d][p] <= PPN_W'(p);
          else if (sel) ent[s][d][p] <= ent_data;
        end
      end
    end
  end

  always_comb look_ppn = ent[look_set][look_dir][look_page];
endmodule

// File: rtl/pxlat_unit.sv
module pxlat_unit
  import pxlat_pkg::*;
#(
  parameter int SETS      = 4,
  parameter int PAGE_BITS = 4,
  parameter int OFF_BITS  = 12,
  parameter int PPN_W     = 8,
  localparam int VA_W     = PAGE_BITS + OFF_BITS,
  localparam int PA_W     = PPN_W + OFF_BITS,
  localparam int SET_W    = $clog2(SETS),
  localparam int IDX_W    = SET_W + 1 + PAGE_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  cpu_addr,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic             io_wr,
  input  logic [1:0]       io_addr,
  input  logic [PPN_W-1:0] io_data,
  output logic [PA_W-1:0]  phys_addr,
  output logic             phys_valid
);
  logic                 ent_we, ent_dir;
  logic [SET_W-1:0]     ent_set, act_set;
  logic [PAGE_BITS-1:0] ent_page;
  logic [PPN_W-1:0]     ent_data, look_ppn;
  logic [IDX_W-1:0]     idx_q;
  logic                 look_dir;

  pxlat_ctrl #(.SETS(SETS), .PAGE_BITS(PAGE_BITS), .PPN_W(PPN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
    .ent_we(ent_we), .ent_set(ent_set), .ent_dir(ent_dir), .ent_page(ent_page),
    .ent_data(ent_data), .act_set(act_set), .idx_q(idx_q)
  );

  assign look_dir = cpu_wr ? 1'(DIR_WRITE) : 1'(DIR_READ);

  pxlat_tables #(.SETS(SETS), .PAGE_BITS(PAGE_BITS), .PPN_W(PPN_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .ent_we(ent_we), .ent_set(ent_set), .ent_dir(ent_dir),
    .ent_page(ent_page), .ent_data(ent_data), .look_set(act_set), .look_dir(look_dir),
    .look_page(cpu_addr[VA_W-1 -: PAGE_BITS]), .look_ppn(look_ppn)
  );

  assign phys_addr  = {look_ppn, cpu_addr[OFF_BITS-1:0]};
  assign phys_valid = cpu_rd | cpu_wr;
endmodule

// File: rtl/pxlat_chk.sv
module pxlat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_wr,
  input logic        io_wr,
  input logic [1:0]  io_addr,
  input logic [7:0]  io_data,
  input logic [19:0] phys_addr,
  input logic [1:0]  act_set,
  input logic [6:0]  idx
);
  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[11:0] == cpu_addr[11:0]);

  // R4
  index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 2'd0) |=> idx == $past(io_data[6:0]));

  // R5
  index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 2'd1) |=> idx == 7'($past(idx) + 7'd1));

  // R6
  set_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 2'd2) |=> act_set == $past(io_data[1:0]));

  // R10
  spare_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 2'd3) |=> ($stable(idx) && $stable(act_set)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(io_wr) && $stable(cpu_addr) && $stable(cpu_wr)) |-> $stable(phys_addr));
endmodule

bind pxlat_unit pxlat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
  .io_wr(io_wr), .io_addr(io_addr), .io_data(io_data),
  .phys_addr(phys_addr), .act_set(act_set), .idx(idx_q)
);

// File: tb/pxlat_unit_test.sv
module pxlat_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 0, cpu_wr = 0, io_wr = 0;
  logic [1:0]  io_addr = '0;
  logic [7:0]  io_data = '0;
  logic [19:0] phys_addr;
  logic        phys_valid;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  pxlat_unit uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic io_put(input logic [1:0] port, input logic [7:0] val);
    @(negedge clk);
    io_wr = 1; io_addr = port; io_data = val;
    @(negedge clk);
    io_wr = 0;
  endtask

  task automatic look(input string req, input logic [15:0] a, input logic rd,
                      input logic wr, input logic [7:0] ppn);
    logic [19:0] exp;
    cpu_addr = a; cpu_rd = rd; cpu_wr = wr;
    #1;
    exp = {ppn, a[11:0]};
    n_chk++;
    if (phys_addr !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h got %h expected %h", req, a, phys_addr, exp);
    end
    if (phys_valid !== (rd | wr)) begin
      n_bad++;
      $display("FAIL R9 valid got %b expected %b", phys_valid, rd | wr);
    end
  endtask

  task automatic t_reset;
    for (int p = 0; p < 16; p++) begin
      look("R8", {4'(p), 12'h5A3}, 1, 0, 8'(p));
      look("R8", {4'(p), 12'h0FF}, 0, 1, 8'(p));
    end
    look("R9", 16'h1234, 0, 0, 8'h01);
  endtask

  task automatic t_dirs;
    io_put(2'd1, 8'h88);                 // index 0 after reset: set0 read page0
    look("R8", 16'h0010, 1, 0, 8'h88);
    io_put(2'd0, 8'h15);                 // set0 write page5
    io_put(2'd1, 8'hA5);
    look("R3", 16'h5ABC, 1, 0, 8'h05);
    look("R3", 16'h5ABC, 0, 1, 8'hA5);
    look("R11", 16'h5001, 1, 1, 8'hA5);
  endtask

  task automatic t_autoinc;
    io_put(2'd0, 8'h08);
    io_put(2'd1, 8'h30);
    io_put(2'd1, 8'h31);
    io_put(2'd1, 8'h32);
    look("R5", 16'h8000, 1, 0, 8'h30);
    look("R5", 16'h9FFF, 1, 0, 8'h31);
    look("R5", 16'hA123, 1, 0, 8'h32);
    look("R4", 16'hB123, 1, 0, 8'h0B);
  endtask

  task automatic t_sets;
    io_put(2'd0, 8'h22);                 // set1 read page2
    io_put(2'd1, 8'hC2);
    look("R7", 16'h2444, 1, 0, 8'h02);
    io_put(2'd2, 8'h01);
    look("R6", 16'h2444, 1, 0, 8'hC2);
    look("R8", 16'h3444, 1, 0, 8'h03);
    look("R8", 16'h5444, 0, 1, 8'h05);
    io_put(2'd3, 8'h00);
    look("R10", 16'h2444, 1, 0, 8'hC2);
    io_put(2'd2, 8'h00);
    look("R6", 16'h5444, 0, 1, 8'hA5);
  endtask

  task automatic t_wrap;
    io_put(2'd0, 8'h7F);                 // set3 write page15
    io_put(2'd1, 8'h77);
    io_put(2'd1, 8'h99);                 // wraps to set0 read page0
    look("R5", 16'h0777, 1, 0, 8'h99);
    io_put(2'd2, 8'h03);
    look("R5", 16'hF777, 0, 1, 8'h77);
    look("R5", 16'hF777, 1, 0, 8'h0F);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_dirs;
    t_autoinc;
    t_sets;
    t_wrap;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule